// File: doc/BRIEF.md
# Block-Write Clock Configuration Slave

This block is a two-wire serial slave on a clock-generator die. It loads a small bank of 8-bit control bytes. The bytes gate the individual clock outputs and can override the hardware frequency-select straps. It watches SCL and SDA in the system clock domain and drives SDA only through an open-drain enable. It recognises START and STOP conditions and accepts a single transaction type: a block write to its fixed address.

A transaction has a fixed order: the address byte, a command byte, a byte-count byte, then the data bytes. The slave acknowledges every byte of a transaction addressed to it. It throws away the command byte and the count byte without looking at their values. The data bytes land in register 0, then register 1, and onward. The master may end with STOP after any whole byte, and every byte acknowledged up to that point stays written.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: An address byte of 0xD2 (7-bit address 0x69 followed by write bit 0) is acknowledged: the block pulls SDA low for the whole ninth clock of that byte.
- R2: SDA is driven only in an acknowledge slot, and the drive enable changes only while SCL is low.
- R3: The two bytes after the address (command, then count) are acknowledged, and no value of either one changes any register.
- R4: Each byte arrives MSB first. The first data byte goes to register 0, the second to register 1, and so on. The outputs map as follows: en_fix_o = reg0[2:1], en_mem_o = reg1[7:0], en_bus_o = reg2[7:1], sel_ovr_o = reg4[3], and sel_o = {reg4[2], reg4[7:4]}.
- R5: After a STOP that follows any complete data byte, every acknowledged byte has taken effect. Registers not reached keep their values.
- R6: Any other address byte, including the read form 0xD3, gets no acknowledge. All bytes after it are ignored with no acknowledge and no write, until the next START.
- R7: After reset, register 0 = 0x06, register 1 = 0xFF, register 2 = 0xFE, and register 4 = 0x00.
- R8: Data bytes past register 4 are acknowledged but change nothing.
- R9: A repeated START in the middle of a transaction begins a new address phase, and the data index goes back to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain pull-low enable for SDA |
| en_fix_o | output | 2 | Enables of the two fixed-frequency output groups |
| en_mem_o | output | 8 | Enables of the memory clock outputs |
| en_bus_o | output | 7 | Enables of the peripheral bus clock outputs |
| sel_o | output | 5 | Software frequency select, MSB first |
| sel_ovr_o | output | 1 | When 1, sel_o overrides the strap select |

## Verification
The table-driven part runs complete block writes of one to five data bytes, with arbitrary command and count values. Different lengths show that short transfers leave the later registers alone. The varied header bytes show that the header never lands in a register. Directed runs cover four further cases:
- a foreign address and the read address, which tell a NACK-and-ignore from a write;
- an over-long transfer, which separates acknowledging a byte from storing it;
- a repeated START, which shows that the byte index resets;
- a line monitor, which flags any change of the drive enable while SCL is high.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_SKIP} slv_state_e;

    localparam logic [7:0] DEV_ADDR_W = 8'hD2;
    localparam int         HDR_BYTES  = 3;  // address, command, count

    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'h06;
            1:       return 8'hFF;
            2:       return 8'hFE;
            4:       return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h06;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_p  = q.scl_sh[SYNC_STAGES-1];
        d.sda_p  = q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s    = q.scl_sh[SYNC_STAGES-1];
    assign sda_s    = q.sda_sh[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~q.scl_p;
    assign scl_fall = ~scl_s & q.scl_p;
    assign start_ev = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/clkcfg_blockwrite_ctrl.sv
module clkcfg_blockwrite_ctrl
    import clkcfg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    typedef struct packed {
        slv_state_e       st;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic [IDX_W-1:0] bidx;
        logic             oe;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.bidx - IDX_W'(HDR_BYTES);
        wr_data = q.shreg;
        case (q.st)
            ST_RX: begin
                if (scl_rise && q.bitcnt < 4'd8) begin
                    d.shreg  = {q.shreg[6:0], sda_s};
                    d.bitcnt = q.bitcnt + 4'd1;
                end else if (scl_fall && q.bitcnt == 4'd8) begin
                    if (q.bidx == '0 && q.shreg != DEV_ADDR_W) begin
                        d.st = ST_SKIP;
                    end else begin
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        wr_en = (q.bidx >= IDX_W'(HDR_BYTES));
                    end
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    d.oe     = 1'b0;
                    d.st     = ST_RX;
                    d.bitcnt = '0;
                    if (q.bidx != '1) d.bidx = q.bidx + 1'b1;
                end
            end
            default: ;
        endcase
        if (start_ev) begin
            d.st     = ST_RX;
            d.bitcnt = '0;
            d.bidx   = '0;
            d.oe     = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, bitcnt: '0, shreg: '0, bidx: '0, oe: 1'b0};
        else        q <= d;
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int IDX_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [7:0]               wr_data,
    output logic [NUM_REGS-1:0][7:0] regs_o
);
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= reg_reset(gi);
            else if (wr_en && wr_idx == IDX_W'(gi))
                byte_q <= wr_data & reg_mask(gi);
        end
        assign regs_o[gi] = byte_q;
    end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave #(
    parameter int NUM_REGS    = 5,
    parameter int MAX_DATA    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [1:0] en_fix_o,
    output logic [7:0] en_mem_o,
    output logic [6:0] en_bus_o,
    output logic [4:0] sel_o,
    output logic       sel_ovr_o
);
    localparam int IDX_W = $clog2(MAX_DATA + clkcfg_pkg::HDR_BYTES + 2);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0] wr_data;
    logic [NUM_REGS-1:0][7:0] regs;

    clkcfg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    clkcfg_blockwrite_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    clkcfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_o(regs)
    );

    assign en_fix_o  = regs[0][2:1];
    assign en_mem_o  = regs[1];
    assign en_bus_o  = regs[2][7:1];
    assign sel_ovr_o = regs[4][3];
    assign sel_o     = {regs[4][2], regs[4][7:4]};

    logic unused_bits;
    assign unused_bits = ^{regs[0][7:3], regs[0][0], regs[2][0], regs[3], regs[4][1:0]};
endmodule

// File: rtl/clkcfg_smbus_checker.sv
module clkcfg_smbus_checker #(
    parameter int NUM_REGS = 5,
    parameter int IDX_W    = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     scl_s,
    input logic                     start_ev,
    input logic                     sda_oe_o,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic [NUM_REGS-1:0][7:0] regs
);
    // R2: drive enable never moves while SCL stays high
    p_oe_steady_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    // R5: registers only change on a write strobe
    p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R4: every stored data byte is acknowledged
    p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe_o);

    // R8: writes past the last register leave the bank untouched
    p_beyond_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs));

    // R9: a START always leaves SDA released
    p_start_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o);
endmodule

bind clkcfg_smbus_slave clkcfg_smbus_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
    .sda_oe_o(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .regs(regs)
);

// File: tb/tb_clkcfg_smbus_slave.sv
`timescale 1ns/1ps
module tb_clkcfg_smbus_slave;
    localparam int Q = 6;  // system cycles per quarter of a serial bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_oe_o;
    wire  sda_line = sda_m & ~sda_oe_o;
    logic [1:0] en_fix_o;
    logic [7:0] en_mem_o;
    logic [6:0] en_bus_o;
    logic [4:0] sel_o;
    logic       sel_ovr_o;

    always #5 clk = ~clk;

    clkcfg_smbus_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .en_fix_o(en_fix_o), .en_mem_o(en_mem_o),
        .en_bus_o(en_bus_o), .sel_o(sel_o), .sel_ovr_o(sel_ovr_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] mdl [0:4];

    // vector: {count of data bytes, command byte, data0..data4}
    localparam logic [55:0] VEC [0:5] = '{
        {8'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'd3, 8'hFF, 8'h5A, 8'h3C, 8'h81, 8'h00, 8'h00},
        {8'd5, 8'h20, 8'hFF, 8'h00, 8'hFF, 8'hAB, 8'hF8},
        {8'd2, 8'h7E, 8'h12, 8'h34, 8'h00, 8'h00, 8'h00},
        {8'd5, 8'h00, 8'h06, 8'hFF, 8'hFE, 8'h00, 8'hA4},
        {8'd4, 8'h81, 8'h00, 8'h00, 8'h00, 8'h77, 8'h00}
    };

    function automatic logic [7:0] bmask(input int i);
        case (i)
            0: return 8'h06; 1: return 8'hFF; 2: return 8'hFE; 4: return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [22:0] expect_pack();
        return {mdl[0][2:1], mdl[1], mdl[2][7:1], mdl[4][3], mdl[4][2], mdl[4][7:4]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, {9'd0, en_fix_o, en_mem_o, en_bus_o, sel_ovr_o, sel_o}, {9'd0, expect_pack()});
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(2);
        sda_m = 1'b0; wq(2);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(2);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        acked = ~sda_line;
        wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    // R2 line monitor: drive enable must not change while SCL is high
    logic oe_prev = 1'b0;
    int   r2_viol = 0;
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe_o !== oe_prev)) r2_viol++;
        oe_prev <= sda_oe_o;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        int nack_cnt;
        for (int i = 0; i < 5; i++) mdl[i] = (i == 0) ? 8'h06 : (i == 1) ? 8'hFF : (i == 2) ? 8'hFE : 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: reset values
        check_outputs("R7 reset");
        check("R7 oe idle", {31'd0, sda_oe_o}, 32'd0);

        // R1 R3 R4 R5: table of block writes
        for (int v = 0; v < 6; v++) begin
            int k = int'(VEC[v][55:48]);
            nack_cnt = 0;
            bus_start();
            send_byte(8'hD2, ack); if (!ack) nack_cnt++;
            send_byte(VEC[v][47:40], ack); if (!ack) nack_cnt++;
            send_byte(VEC[v][55:48], ack); if (!ack) nack_cnt++;
            for (int j = 0; j < k; j++) begin
                logic [7:0] db = VEC[v][39 - 8*j -: 8];
                send_byte(db, ack); if (!ack) nack_cnt++;
                mdl[j] = db & bmask(j);
            end
            bus_stop();
            check("R1 R3 acks", nack_cnt, 0);
            check_outputs("R4 R5 registers");
        end

        // R6: foreign address, then bytes that must be ignored
        nack_cnt = 0;
        bus_start();
        send_byte(8'hA4, ack); if (ack) nack_cnt++;
        send_byte(8'h00, ack); if (ack) nack_cnt++;
        send_byte(8'h01, ack); if (ack) nack_cnt++;
        send_byte(8'h00, ack); if (ack) nack_cnt++;
        bus_stop();
        check("R6 foreign no ack", nack_cnt, 0);
        check_outputs("R6 foreign no write");

        // R6: read address form
        nack_cnt = 0;
        bus_start();
        send_byte(8'hD3, ack); if (ack) nack_cnt++;
        send_byte(8'h00, ack); if (ack) nack_cnt++;
        send_byte(8'h11, ack); if (ack) nack_cnt++;
        bus_stop();
        check("R6 read no ack", nack_cnt, 0);
        check_outputs("R6 read no write");

        // R8: seven data bytes, two past the bank
        nack_cnt = 0;
        bus_start();
        send_byte(8'hD2, ack); if (!ack) nack_cnt++;
        send_byte(8'h00, ack); if (!ack) nack_cnt++;
        send_byte(8'h07, ack); if (!ack) nack_cnt++;
        for (int j = 0; j < 7; j++) begin
            logic [7:0] db = 8'h31 + 8'(j * 17);
            send_byte(db, ack); if (!ack) nack_cnt++;
            if (j < 5) mdl[j] = db & bmask(j);
        end
        bus_stop();
        check("R8 extra acked", nack_cnt, 0);
        check_outputs("R8 extra discarded");

        // R9: repeated START restarts index at register 0
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h02, ack);
        send_byte(8'hAA, ack);
        mdl[0] = 8'hAA & bmask(0);
        bus_start();
        nack_cnt = 0;
        send_byte(8'hD2, ack); if (!ack) nack_cnt++;
        send_byte(8'h00, ack); if (!ack) nack_cnt++;
        send_byte(8'h01, ack); if (!ack) nack_cnt++;
        send_byte(8'h04, ack); if (!ack) nack_cnt++;
        mdl[0] = 8'h04 & bmask(0);
        bus_stop();
        check("R9 restart acks", nack_cnt, 0);
        check_outputs("R9 restart index");

        // R2: accumulated line monitor result
        check("R2 oe steady while SCL high", r2_viol, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule